// File: doc/BRIEF.md
# Valley-Skipping Switch-On Scheduler

This block is the digital core of a quasi-resonant flyback controller that cuts the switching frequency as the load drops. After each gate turn-off it waits out a ringing-suppression time. It then counts the transformer demagnetization zero-crossings (valleys) and asks for the next turn-on at valley number N. Turning on in a valley keeps the drain voltage at its lowest when the switch closes.

N is a saturating up/down index from 1 to 15. It moves by at most one step at the end of each fixed update window. The step follows a vote between two window flags, which record whether the regulation voltage passed a low and a high comparator threshold during the window. This hysteresis keeps N from hunting under a load that changes all the time. A third comparator, for a regulation voltage far above target, bypasses the window and forces N back to 1 at once, so that full power is available again straight after a load step.

The comparators, the gate driver and the logic that ends the on-time sit outside this block. It receives an already synchronised one-cycle pulse for each zero-crossing and a one-cycle pulse marking each gate turn-off.

Top module: `valley_step_ctrl`

## Requirements
- R1: After reset the valley index reads 1 and the turn-on request is low.
- R2: When neither window flag was raised during a window, the index rises by one at the window's last clock edge.
- R3: When only the low flag was raised during a window, the index holds at that window's end.
- R4: When the high flag was raised during a window, the index falls by one at the window's end, whether or not the low flag was also raised.
- R5: The index saturates at 1 and at 15 and never wraps.
- R6: A comparator level seen in the last cycle of a window counts for that window. Both flags are cleared at every window end, so they do not carry into the next window.
- R7: Apart from the fast load, the index changes only at a window end, and by at most one step.
- R8: A cycle with the overload comparator high loads the index with 1 at the next edge. This load overrides any window update that falls on the same edge.
- R9: A turn-off pulse restarts the valley count. Zero-crossing pulses in the turn-off cycle and in the BLANK_CYC cycles after it are ignored.
- R10: The turn-on request is a single-cycle pulse. It appears in the cycle after the N-th zero-crossing pulse that is counted.
- R11: After a turn-on request, further zero-crossing pulses are ignored until the next turn-off pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| off_start | input | 1 | One-cycle pulse at each gate turn-off |
| zc_pulse | input | 1 | Synchronised one-cycle zero-crossing pulse |
| cmp_lo | input | 1 | Regulation voltage above the low threshold |
| cmp_hi | input | 1 | Regulation voltage above the high threshold |
| cmp_max | input | 1 | Regulation voltage above the overload threshold |
| turn_on | output | 1 | One-cycle request to start the next on-time |
| valley_n | output | CNT_W | Current valley index N |

## Verification
The fast load to 1 and the regular window update can fall on the same clock edge. The bench provokes this by raising the overload comparator in exactly the last cycle of a window that has no flags. A correct design must then read 1, not the incremented value. The bench also raises the overload input in the middle of a window with no flags. There it expects 1 at once and then 2 at the window end, which shows that the fast load leaves the window flags and the window phase alone. A comparator pulse placed in the final window cycle, followed by a window with no flags, shows that the flags are counted in that cycle and then cleared.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
   // Decision taken at the end of each update window.
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } step_e;
endpackage

// File: rtl/vsc_window.sv
module vsc_window
   import vsc_pkg::*;
#(
   parameter int WIN_CYC = 50000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  cmp_lo,
   input  logic  cmp_hi,
   output logic  win_end,
   output step_e step
);
   localparam int WW = (WIN_CYC > 2) ? $clog2(WIN_CYC) : 1;
   localparam logic [WW-1:0] LAST = WW'(WIN_CYC - 1);

   if (WIN_CYC < 2) begin : g_bad_win
      $error("vsc_window: WIN_CYC must be at least 2");
   end

   logic [WW-1:0] phase;
   logic          lo_flag, hi_flag;
   logic          lo_seen, hi_seen;

   // Include the present cycle so the last window cycle still counts.
   assign lo_seen = lo_flag | cmp_lo;
   assign hi_seen = hi_flag | cmp_hi;
   assign win_end = (phase == LAST);

   always_comb begin
      if (hi_seen)      step = STEP_DOWN;
      else if (lo_seen) step = STEP_HOLD;
      else              step = STEP_UP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= '0;
         lo_flag <= 1'b0;
         hi_flag <= 1'b0;
      end else begin
         phase   <= win_end ? '0 : phase + 1'b1;
         lo_flag <= win_end ? 1'b0 : lo_seen;
         hi_flag <= win_end ? 1'b0 : hi_seen;
      end
   end

   a_r6_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> (!lo_flag && !hi_flag));

   a_r7_phase_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> (phase == '0));
endmodule

// File: rtl/vsc_index.sv
module vsc_index
   import vsc_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_end,
   input  step_e            step,
   input  logic             cmp_max,
   output logic [CNT_W-1:0] idx
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("vsc_index: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] idx_nxt;

   always_comb begin
      idx_nxt = idx;
      if (cmp_max) begin
         idx_nxt = ONE;
      end else if (win_end) begin
         case (step)
            STEP_UP:   if (idx != TOP) idx_nxt = idx + 1'b1;
            STEP_DOWN: if (idx != ONE) idx_nxt = idx - 1'b1;
            default:   idx_nxt = idx;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx <= ONE;
      else        idx <= idx_nxt;
   end

   a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (idx >= ONE) && (idx <= TOP));

   a_r8_fast_load: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_max |=> (idx == ONE));

   a_r7_only_at_window: assert property (@(posedge clk) disable iff (!rst_n)
      (!win_end && !cmp_max) |=> $stable(idx));

   a_r7_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_max |=> (idx == $past(idx) || idx == $past(idx) + 1'b1
                    || idx == $past(idx) - 1'b1));

   a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && !cmp_max && step == STEP_UP && idx != TOP)
      |=> (idx == $past(idx) + 1'b1));

   a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && !cmp_max && step == STEP_DOWN && idx != ONE)
      |=> (idx == $past(idx) - 1'b1));
endmodule

// File: rtl/vsc_valley.sv
module vsc_valley #(
   parameter int CNT_W     = 4,
   parameter int BLANK_CYC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             off_start,
   input  logic             zc_pulse,
   input  logic [CNT_W-1:0] idx,
   output logic             turn_on
);
   if (BLANK_CYC < 0) begin : g_bad_blank
      $error("vsc_valley: BLANK_CYC must not be negative");
   end

   logic             blank_done;
   logic [CNT_W-1:0] zc_cnt;
   logic             armed;
   logic             zc_ok;
   logic             hit;

   if (BLANK_CYC > 0) begin : g_blank
      localparam int BW = $clog2(BLANK_CYC + 1);
      logic [BW-1:0] blank;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               blank <= '0;
         else if (off_start)       blank <= BW'(BLANK_CYC);
         else if (blank != '0)     blank <= blank - 1'b1;
      end
      assign blank_done = (blank == '0);

      a_r9_blanked: assert property (@(posedge clk) disable iff (!rst_n)
         (blank != '0) |=> !turn_on);
   end else begin : g_no_blank
      assign blank_done = 1'b1;
   end

   assign zc_ok = armed && blank_done && zc_pulse && !off_start;
   // Reaching or passing the index both end the wait.
   assign hit   = zc_ok && (({1'b0, zc_cnt} + 1'b1) >= {1'b0, idx});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zc_cnt  <= '0;
         armed   <= 1'b0;
         turn_on <= 1'b0;
      end else begin
         turn_on <= hit;
         if (off_start) begin
            zc_cnt <= '0;
            armed  <= 1'b1;
         end else if (hit) begin
            zc_cnt <= '0;
            armed  <= 1'b0;
         end else if (zc_ok) begin
            zc_cnt <= zc_cnt + 1'b1;
         end
      end
   end

   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      turn_on |=> !turn_on);

   a_r11_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
      turn_on |-> !armed);

   a_r9_off_restart: assert property (@(posedge clk) disable iff (!rst_n)
      off_start |=> (armed && zc_cnt == '0 && !turn_on));
endmodule

// File: rtl/valley_step_ctrl.sv
module valley_step_ctrl
   import vsc_pkg::*;
#(
   parameter int CNT_W     = 4,
   parameter int WIN_CYC   = 50000,
   parameter int BLANK_CYC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             off_start,
   input  logic             zc_pulse,
   input  logic             cmp_lo,
   input  logic             cmp_hi,
   input  logic             cmp_max,
   output logic             turn_on,
   output logic [CNT_W-1:0] valley_n
);
   logic  win_end;
   step_e step;

   vsc_window #(.WIN_CYC(WIN_CYC)) u_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmp_lo  (cmp_lo),
      .cmp_hi  (cmp_hi),
      .win_end (win_end),
      .step    (step)
   );

   vsc_index #(.CNT_W(CNT_W)) u_index (
      .clk     (clk),
      .rst_n   (rst_n),
      .win_end (win_end),
      .step    (step),
      .cmp_max (cmp_max),
      .idx     (valley_n)
   );

   vsc_valley #(.CNT_W(CNT_W), .BLANK_CYC(BLANK_CYC)) u_valley (
      .clk       (clk),
      .rst_n     (rst_n),
      .off_start (off_start),
      .zc_pulse  (zc_pulse),
      .idx       (valley_n),
      .turn_on   (turn_on)
   );
endmodule

// File: tb/valley_step_ctrl_test.sv
module valley_step_ctrl_test;
   localparam int CLK_P = 10;
   localparam int W     = 4;
   localparam int WIN   = 16;
   localparam int BLANK = 3;
   localparam int NMAX  = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         off_start = 1'b0, zc_pulse = 1'b0;
   logic         cmp_lo = 1'b0, cmp_hi = 1'b0, cmp_max = 1'b0;
   logic         turn_on;
   logic [W-1:0] valley_n;

   int n_chk = 0, n_bad = 0;
   int exp_n = 1;

   always #(CLK_P/2) clk = ~clk;

   valley_step_ctrl #(.CNT_W(W), .WIN_CYC(WIN), .BLANK_CYC(BLANK)) uut (
      .clk(clk), .rst_n(rst_n), .off_start(off_start), .zc_pulse(zc_pulse),
      .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .cmp_max(cmp_max),
      .turn_on(turn_on), .valley_n(valley_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int step_model(input int n, input bit lo, input bit hi);
      if (hi)      return (n > 1) ? n - 1 : 1;          // R4, R5
      else if (lo) return n;                            // R3
      else         return (n < NMAX) ? n + 1 : NMAX;    // R2, R5
   endfunction

   // One full window, entered at the negedge before its first cycle.
   task automatic run_window(input int lo_at, input int hi_at, input int max_at);
      int start = exp_n;
      for (int c = 0; c < WIN; c++) begin
         cmp_lo  = (c == lo_at);
         cmp_hi  = (c == hi_at);
         cmp_max = (c == max_at);
         @(negedge clk);
         cmp_lo = 1'b0; cmp_hi = 1'b0; cmp_max = 1'b0;
         if (c == max_at && c < WIN - 1)
            check(valley_n == 1, "R8 immediate load", valley_n, 1);
         else if (c < WIN - 1 && (max_at < 0 || c < max_at))
            check(valley_n == start, "R7 no change inside window", valley_n, start);
      end
      if (max_at == WIN - 1) exp_n = 1;
      else if (max_at >= 0)  exp_n = step_model(1, lo_at >= 0, hi_at >= 0);
      else                   exp_n = step_model(exp_n, lo_at >= 0, hi_at >= 0);
      check(valley_n == exp_n, "R2/R3/R4/R6/R8 window end", valley_n, exp_n);
   endtask

   task automatic set_n(input int k);
      int guard = 0;
      cmp_lo = 1'b0; cmp_hi = 1'b0;
      cmp_max = 1'b1;
      @(negedge clk);
      cmp_max = 1'b0;
      while (valley_n != k && guard < 40 * WIN) begin
         @(negedge clk);
         guard++;
      end
      cmp_lo = 1'b1;   // low flag only: index holds from here on
   endtask

   task automatic off_blank;
      off_start = 1'b1; zc_pulse = 1'b1;
      @(negedge clk);
      off_start = 1'b0;
      check(turn_on == 1'b0, "R9 no request at turn-off", turn_on, 0);
      for (int j = 0; j < BLANK; j++) begin
         @(negedge clk);
         check(turn_on == 1'b0, "R9 blanked zero-crossing", turn_on, 0);
      end
      zc_pulse = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_zc(input bit expect_on, input string req);
      zc_pulse = 1'b1;
      @(negedge clk);
      zc_pulse = 1'b0;
      check(turn_on == expect_on, req, turn_on, expect_on);
      @(negedge clk);
      check(turn_on == 1'b0, "R10 single-cycle request", turn_on, 0);
   endtask

   task automatic valley_test(input int k, input int restart_after);
      set_n(k);
      check(valley_n == k, "R10 index setup", valley_n, k);
      off_blank();
      if (restart_after > 0) begin
         for (int i = 0; i < restart_after; i++) pulse_zc(1'b0, "R9 before restart");
         off_blank();
      end
      for (int i = 1; i <= k; i++)
         pulse_zc(i == k, "R10 turn-on at Nth valley");
      pulse_zc(1'b0, "R11 ignored after request");
      pulse_zc(1'b0, "R11 still ignored");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(valley_n == 1, "R1 reset index", valley_n, 1);
      check(turn_on == 1'b0, "R1 reset request", turn_on, 0);
      rst_n = 1'b1;

      run_window(-1, -1, -1);          // R2 -> 2
      run_window(-1, -1, -1);          // R2 -> 3
      run_window(WIN - 1, -1, -1);     // R6 lo in last cycle, hold
      run_window(-1, -1, -1);          // R6 flags cleared -> 4
      run_window(4, -1, -1);           // R3 hold
      run_window(2, 9, -1);            // R4 both -> 3
      run_window(-1, 7, -1);           // R4 high only -> 2
      run_window(-1, 5, -1);           // -> 1
      run_window(3, 3, -1);            // R5 floor
      for (int w = 0; w < NMAX; w++)
         run_window(-1, -1, -1);       // R5 climb to ceiling and hold
      run_window(-1, -1, 6);           // R8 mid-window load then step
      run_window(-1, -1, WIN - 1);     // R8 collision with window end

      valley_test(1, 0);
      valley_test(2, 0);
      valley_test(3, 2);               // R9 restart mid-count
      valley_test(5, 0);
      valley_test(NMAX, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule